// File: doc/BRIEF.md
# RTC Interrupt Status Controller

This block holds the interrupt status and enable state of a real-time clock. Timing sources outside it deliver single-cycle event pulses: a set of periodic ticks at fixed rates, an alarm match, two general timers and a power-fail event. A power-good level arrives as well. The block latches each event into a status flag. It masks the flags with software-written enables and drives an interrupt onto one of two active-low pins. It also offers a summary bit so that a host sharing one interrupt line can poll the block quickly.

Software reaches the block through a small paged register bus. The bus has an address, a page bit, a read strobe and a write strobe. Read data is combinational during the strobe cycle. Writes take effect at the clock edge that ends the strobe cycle. Each kind of flag has its own way of being cleared. The alarm and timer 0 flags clear when a one is written to them. The timer 1 flag clears when the status register is read, and the periodic flags clear when their register is read. The power-fail flag clears only when power returns.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset every flag, enable and mode bit is zero, both pins are high (inactive), and the status and periodic-flag registers read as 0x00.
- R2: Register map. Status is at 0x00 on either page. Periodic flags are at 0x03 page 0. Periodic enables are at 0x03 page 1. Source enables are at 0x04 page 1 (bit0 alarm, bit1 timer 0, bit2 timer 1, bit3 power fail). Pin routing is at 0x02 page 1, bit0. Writable registers read back what was written, and unmapped locations read 0x00.
- R3: A pulse on periodic tick i sets periodic-flag bit i whatever the enables hold. A read of the periodic-flag register returns the flags and clears all of them at the end of that read cycle. A tick in the read cycle keeps its bit set.
- R4: Status bit 1 reads 1 only while some periodic flag is set and its enable bit (same index at 0x03 page 1) is 1.
- R5: Alarm (status bit 2) and timer 0 (status bit 3) set on their events even with their enables at zero. Writing 1 to the bit at 0x00 clears it, and writing 0 leaves it. An event in the same cycle as the clearing write keeps the bit set.
- R6: Timer 1 (status bit 4) sets on its event even with its enable at zero. It clears at the end of any cycle in which status is read, and that read returns 1.
- R7: Power fail (status bit 5) sets only on a power-fail event while its enable is 1. It then holds while the power-good input is low, whatever software writes. It clears at the end of the first cycle in which power-good is high and no new event arrives.
- R8: An interrupt is pending when status bit 1 is set, or bits 2 to 5 are set together with their own enables. The pin changes one clock edge after the pending condition changes. Routing bit 0 drives the interrupt pin low and routing bit 1 drives the multi-function pin low.
- R9: With every enable bit at zero both pins stay high, while the status flags still set and read back.
- R10: Status bit 0 reads 1 exactly when either pin is low.
- R11: The two pins are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Register address |
| bus_page | input | 1 | Page select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while bus_rd is high |
| ev_tick | input | NPER | Periodic tick pulses, one per rate |
| ev_alarm | input | 1 | Alarm match pulse |
| ev_tmr0 | input | 1 | Timer 0 expiry pulse |
| ev_tmr1 | input | 1 | Timer 1 expiry pulse |
| pf_event | input | 1 | Power-fail event pulse |
| pwr_ok | input | 1 | Power-good level |
| intr_n | output | 1 | Active-low interrupt pin |
| mfo_n | output | 1 | Active-low multi-function pin |

## Verification
An event pulse shows in a register read in the cycle after it, because one flag register lies between them. It reaches a pin one edge later again, through the output register. A write or a read side effect is visible from the cycle after the strobe, so a read returns the value from before its own clear. The bench drives each vector on the falling edge and compares bus data 1 ns later within that cycle. Before it checks a pin it places an idle vector after the flag or enable change, so that both register stages have been passed.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   // Register locations (5-bit view, zero-extended to the bus width)
   localparam logic [4:0] LOC_STAT = 5'h00;
   localparam logic [4:0] LOC_ROUTE = 5'h02;
   localparam logic [4:0] LOC_PER = 5'h03;   // page 0 flags, page 1 enables
   localparam logic [4:0] LOC_SRCEN = 5'h04;
   // Status bit positions
   localparam int unsigned SB_SUM = 0;
   localparam int unsigned SB_PER = 1;
   localparam int unsigned SB_ALM = 2;
   localparam int unsigned SB_TM0 = 3;
   localparam int unsigned SB_TM1 = 4;
   localparam int unsigned SB_PWF = 5;
   // Source enable bit positions
   localparam int unsigned EN_ALM = 0;
   localparam int unsigned EN_TM0 = 1;
   localparam int unsigned EN_TM1 = 2;
   localparam int unsigned EN_PWF = 3;
   localparam int unsigned SRC_N = 4;
endpackage

// File: rtl/rtc_irq_decode.sv
module rtc_irq_decode
   import rtc_irq_pkg::*;
#(
   parameter int unsigned AW = 5
) (
   input  logic [AW-1:0] addr,
   input  logic          page,
   input  logic          rd,
   input  logic          wr,
   output logic          hit_stat,
   output logic          hit_per,
   output logic          hit_pen,
   output logic          hit_src,
   output logic          hit_route,
   output logic          stat_rd,
   output logic          stat_wr,
   output logic          per_rd,
   output logic          pen_wr,
   output logic          src_wr,
   output logic          route_wr
);
   always_comb begin
      hit_stat  = (addr == AW'(LOC_STAT));
      hit_per   = (addr == AW'(LOC_PER)) && !page;
      hit_pen   = (addr == AW'(LOC_PER)) && page;
      hit_src   = (addr == AW'(LOC_SRCEN)) && page;
      hit_route = (addr == AW'(LOC_ROUTE)) && page;
      stat_rd   = rd && hit_stat;
      stat_wr   = wr && hit_stat;
      per_rd    = rd && hit_per;
      pen_wr    = wr && hit_pen;
      src_wr    = wr && hit_src;
      route_wr  = wr && hit_route;
   end
endmodule

// File: rtl/rtc_irq_cfg.sv
module rtc_irq_cfg
   import rtc_irq_pkg::*;
#(
   parameter int unsigned DW   = 8,
   parameter int unsigned NPER = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     wdata,
   input  logic              pen_wr,
   input  logic              src_wr,
   input  logic              route_wr,
   output logic [NPER-1:0]   per_en,
   output logic [SRC_N-1:0]  src_en,
   output logic              route_mfo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_en    <= '0;
         src_en    <= '0;
         route_mfo <= 1'b0;
      end else begin
         if (pen_wr)   per_en    <= wdata[NPER-1:0];
         if (src_wr)   src_en    <= wdata[SRC_N-1:0];
         if (route_wr) route_mfo <= wdata[0];
      end
   end

   // R2
   en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_wr |=> (src_en == $past(wdata[SRC_N-1:0])));
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
   parameter int unsigned NPER = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPER-1:0] ev_tick,
   input  logic            ev_alarm,
   input  logic            ev_tmr0,
   input  logic            ev_tmr1,
   input  logic            pf_event,
   input  logic            pwr_ok,
   input  logic            pf_en,
   input  logic            per_rd,
   input  logic            stat_rd,
   input  logic            clr_alm,
   input  logic            clr_tm0,
   output logic [NPER-1:0] per_flag,
   output logic            alm_flag,
   output logic            tm0_flag,
   output logic            tm1_flag,
   output logic            pwf_flag
);
   for (genvar g = 0; g < NPER; g++) begin : g_per
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          per_flag[g] <= 1'b0;
         else if (ev_tick[g]) per_flag[g] <= 1'b1;
         else if (per_rd)     per_flag[g] <= 1'b0;
      end

      // R3
      per_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (per_rd && !ev_tick[g]) |=> !per_flag[g]);
      // R3
      per_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ev_tick[g] |=> per_flag[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_flag <= 1'b0;
         tm0_flag <= 1'b0;
         tm1_flag <= 1'b0;
         pwf_flag <= 1'b0;
      end else begin
         if (ev_alarm)      alm_flag <= 1'b1;
         else if (clr_alm)  alm_flag <= 1'b0;
         if (ev_tmr0)       tm0_flag <= 1'b1;
         else if (clr_tm0)  tm0_flag <= 1'b0;
         if (ev_tmr1)       tm1_flag <= 1'b1;
         else if (stat_rd)  tm1_flag <= 1'b0;
         if (pf_event && pf_en) pwf_flag <= 1'b1;
         else if (pwr_ok)       pwf_flag <= 1'b0;
      end
   end

   // R5
   alm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_alarm |=> alm_flag);
   // R5
   alm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_alm && !ev_alarm) |=> !alm_flag);
   // R6
   tm1_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !ev_tmr1) |=> !tm1_flag);
   // R7
   pwf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwf_flag && !pwr_ok) |=> pwf_flag);
   // R7
   pwf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwf_flag && !(pf_event && pf_en)) |=> !pwf_flag);
endmodule

// File: rtl/rtc_irq_drive.sv
module rtc_irq_drive #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend,
   input  logic route_mfo,
   output logic intr_n,
   output logic mfo_n
);
   logic intr_d, mfo_d;

   always_comb begin
      intr_d = !(pend && !route_mfo);
      mfo_d  = !(pend && route_mfo);
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            intr_n <= 1'b1;
            mfo_n  <= 1'b1;
         end else begin
            intr_n <= intr_d;
            mfo_n  <= mfo_d;
         end
      end

      // R8
      route_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend && !route_mfo) |=> (!intr_n && mfo_n));
      // R8
      route_mfo_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend && route_mfo) |=> (!mfo_n && intr_n));
      // R9
      idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pend |=> (intr_n && mfo_n));
   end else begin : g_comb
      always_comb begin
         intr_n = intr_d;
         mfo_n  = mfo_d;
      end
   end

   // R11
   pins_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!intr_n && !mfo_n));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int unsigned AW      = 5,
   parameter int unsigned DW      = 8,
   parameter int unsigned NPER    = 5,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   bus_addr,
   input  logic            bus_page,
   input  logic            bus_rd,
   input  logic            bus_wr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NPER-1:0] ev_tick,
   input  logic            ev_alarm,
   input  logic            ev_tmr0,
   input  logic            ev_tmr1,
   input  logic            pf_event,
   input  logic            pwr_ok,
   output logic            intr_n,
   output logic            mfo_n
);
   localparam int unsigned STAT_W = SB_PWF + 1;

   if (AW < 3) begin : g_bad_aw
      $error("rtc_irq_ctrl: AW must be at least 3");
   end
   if (DW < STAT_W) begin : g_bad_dw
      $error("rtc_irq_ctrl: DW must hold the status bits");
   end
   if (NPER < 1 || NPER > DW) begin : g_bad_nper
      $error("rtc_irq_ctrl: NPER must be 1..DW");
   end

   logic hit_stat, hit_per, hit_pen, hit_src, hit_route;
   logic stat_rd, stat_wr, per_rd, pen_wr, src_wr, route_wr;
   logic [NPER-1:0]  per_en, per_flag;
   logic [SRC_N-1:0] src_en;
   logic route_mfo;
   logic alm_flag, tm0_flag, tm1_flag, pwf_flag;
   logic per_hit, pend;
   logic [STAT_W-1:0] stat;

   rtc_irq_decode #(.AW(AW)) u_dec (
      .addr(bus_addr), .page(bus_page), .rd(bus_rd), .wr(bus_wr),
      .hit_stat(hit_stat), .hit_per(hit_per), .hit_pen(hit_pen),
      .hit_src(hit_src), .hit_route(hit_route),
      .stat_rd(stat_rd), .stat_wr(stat_wr), .per_rd(per_rd),
      .pen_wr(pen_wr), .src_wr(src_wr), .route_wr(route_wr)
   );

   rtc_irq_cfg #(.DW(DW), .NPER(NPER)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
      .pen_wr(pen_wr), .src_wr(src_wr), .route_wr(route_wr),
      .per_en(per_en), .src_en(src_en), .route_mfo(route_mfo)
   );

   rtc_irq_flags #(.NPER(NPER)) u_flags (
      .clk(clk), .rst_n(rst_n), .ev_tick(ev_tick), .ev_alarm(ev_alarm),
      .ev_tmr0(ev_tmr0), .ev_tmr1(ev_tmr1), .pf_event(pf_event),
      .pwr_ok(pwr_ok), .pf_en(src_en[EN_PWF]), .per_rd(per_rd),
      .stat_rd(stat_rd),
      .clr_alm(stat_wr && bus_wdata[SB_ALM]),
      .clr_tm0(stat_wr && bus_wdata[SB_TM0]),
      .per_flag(per_flag), .alm_flag(alm_flag), .tm0_flag(tm0_flag),
      .tm1_flag(tm1_flag), .pwf_flag(pwf_flag)
   );

   always_comb begin
      per_hit = |(per_flag & per_en);
      pend = per_hit
           || (alm_flag && src_en[EN_ALM])
           || (tm0_flag && src_en[EN_TM0])
           || (tm1_flag && src_en[EN_TM1])
           || (pwf_flag && src_en[EN_PWF]);
      stat = '0;
      stat[SB_SUM] = !intr_n || !mfo_n;
      stat[SB_PER] = per_hit;
      stat[SB_ALM] = alm_flag;
      stat[SB_TM0] = tm0_flag;
      stat[SB_TM1] = tm1_flag;
      stat[SB_PWF] = pwf_flag;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (hit_stat)       bus_rdata = DW'(stat);
         else if (hit_per)   bus_rdata = DW'(per_flag);
         else if (hit_pen)   bus_rdata = DW'(per_en);
         else if (hit_src)   bus_rdata = DW'(src_en);
         else if (hit_route) bus_rdata = DW'(route_mfo);
      end
   end

   rtc_irq_drive #(.OUT_REG(OUT_REG)) u_drive (
      .clk(clk), .rst_n(rst_n), .pend(pend), .route_mfo(route_mfo),
      .intr_n(intr_n), .mfo_n(mfo_n)
   );

   if (OUT_REG) begin : g_chk_reg
      // R9
      no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (per_en == '0 && src_en == '0) |=> (intr_n && mfo_n));
   end

   // R4
   per_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (per_en == '0) |-> !stat[SB_PER]);
endmodule

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;
   localparam int unsigned AW = 5;
   localparam int unsigned DW = 8;
   localparam int unsigned NPER = 5;

   // vector: {req[3:0], kind[2:0], page, addr[4:0], data[15:0], exp[7:0]}
   // event data: [4:0] ticks, [5] alarm, [6] timer0, [7] timer1,
   //             [8] power-fail event, [9] power low (held until next event vector)
   // pin check exp: bit1 = mfo_n, bit0 = intr_n
   localparam logic [2:0] K_IDLE = 3'd0;
   localparam logic [2:0] K_WR   = 3'd1;
   localparam logic [2:0] K_RD   = 3'd2;
   localparam logic [2:0] K_EV   = 3'd3;
   localparam logic [2:0] K_PIN  = 3'd4;
   localparam int N_VEC = 54;

   localparam logic [36:0] VEC [N_VEC] = '{
      {4'd1,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h00},  // R1 status after reset
      {4'd1,  K_RD,   1'b0, 5'h03, 16'h0000, 8'h00},  // R1 periodic flags after reset
      {4'd1,  K_PIN,  1'b0, 5'h00, 16'h0000, 8'h03},  // R1 pins high
      {4'd3,  K_EV,   1'b0, 5'h00, 16'h0005, 8'h00},  // ticks 0 and 2
      {4'd4,  K_RD,   1'b1, 5'h00, 16'h0000, 8'h00},  // R4 masked, status on page 1
      {4'd3,  K_RD,   1'b0, 5'h03, 16'h0000, 8'h05},  // R3 read returns, then clears
      {4'd3,  K_RD,   1'b0, 5'h03, 16'h0000, 8'h00},  // R3 cleared
      {4'd2,  K_WR,   1'b1, 5'h03, 16'h0002, 8'h00},  // enable tick 1
      {4'd2,  K_RD,   1'b1, 5'h03, 16'h0000, 8'h02},  // R2 read back
      {4'd3,  K_EV,   1'b0, 5'h00, 16'h0002, 8'h00},  // tick 1
      {4'd4,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h02},  // R4 bit1, pin not yet low
      {4'd8,  K_PIN,  1'b0, 5'h00, 16'h0000, 8'h02},  // R8 intr_n low
      {4'd10, K_RD,   1'b0, 5'h00, 16'h0000, 8'h03},  // R10 summary set
      {4'd3,  K_RD,   1'b0, 5'h03, 16'h0000, 8'h02},  // clear periodic
      {4'd0,  K_IDLE, 1'b0, 5'h00, 16'h0000, 8'h00},
      {4'd8,  K_PIN,  1'b0, 5'h00, 16'h0000, 8'h03},  // R8 released
      {4'd10, K_RD,   1'b0, 5'h00, 16'h0000, 8'h00},  // R10 summary clear
      {4'd5,  K_EV,   1'b0, 5'h00, 16'h0020, 8'h00},  // alarm
      {4'd5,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h04},  // R5 set with enable off
      {4'd0,  K_IDLE, 1'b0, 5'h00, 16'h0000, 8'h00},
      {4'd9,  K_PIN,  1'b0, 5'h00, 16'h0000, 8'h03},  // R9 masked, pins high
      {4'd5,  K_WR,   1'b0, 5'h00, 16'h0000, 8'h00},  // write zero
      {4'd5,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h04},  // R5 zero write kept it
      {4'd2,  K_WR,   1'b1, 5'h04, 16'h0001, 8'h00},  // alarm enable
      {4'd2,  K_RD,   1'b1, 5'h04, 16'h0000, 8'h01},  // R2 read back
      {4'd8,  K_PIN,  1'b0, 5'h00, 16'h0000, 8'h02},  // R8 intr_n low
      {4'd2,  K_WR,   1'b1, 5'h02, 16'h0001, 8'h00},  // route to mfo
      {4'd0,  K_IDLE, 1'b0, 5'h00, 16'h0000, 8'h00},
      {4'd8,  K_PIN,  1'b0, 5'h00, 16'h0000, 8'h01},  // R8 mfo_n low only
      {4'd10, K_RD,   1'b0, 5'h00, 16'h0000, 8'h05},  // R10 summary via mfo
      {4'd5,  K_WR,   1'b0, 5'h00, 16'h0004, 8'h00},  // clear alarm
      {4'd0,  K_IDLE, 1'b0, 5'h00, 16'h0000, 8'h00},
      {4'd5,  K_PIN,  1'b0, 5'h00, 16'h0000, 8'h03},  // R5 pins released
      {4'd5,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h00},  // R5 cleared
      {4'd5,  K_EV,   1'b0, 5'h00, 16'h0040, 8'h00},  // timer 0
      {4'd5,  K_RD,   1'b1, 5'h00, 16'h0000, 8'h08},  // R5 timer0 set
      {4'd5,  K_WR,   1'b0, 5'h00, 16'h0008, 8'h00},  // clear timer0
      {4'd5,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h00},  // R5 timer0 cleared
      {4'd6,  K_EV,   1'b0, 5'h00, 16'h0080, 8'h00},  // timer 1
      {4'd6,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h10},  // R6 read returns 1
      {4'd6,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h00},  // R6 read cleared it
      {4'd7,  K_EV,   1'b0, 5'h00, 16'h0300, 8'h00},  // power fail, enable off, power low
      {4'd7,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h00},  // R7 not set without enable
      {4'd7,  K_WR,   1'b1, 5'h04, 16'h0009, 8'h00},  // alarm + power-fail enable
      {4'd7,  K_EV,   1'b0, 5'h00, 16'h0300, 8'h00},  // power fail, power low
      {4'd7,  K_WR,   1'b0, 5'h00, 16'h00FF, 8'h00},  // software write all ones
      {4'd7,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h21},  // R7 held, summary set
      {4'd7,  K_PIN,  1'b0, 5'h00, 16'h0000, 8'h01},  // R7 mfo_n low
      {4'd7,  K_EV,   1'b0, 5'h00, 16'h0000, 8'h00},  // power restored
      {4'd0,  K_IDLE, 1'b0, 5'h00, 16'h0000, 8'h00},
      {4'd7,  K_PIN,  1'b0, 5'h00, 16'h0000, 8'h03},  // R7 pins released
      {4'd7,  K_RD,   1'b0, 5'h00, 16'h0000, 8'h00},  // R7 cleared
      {4'd2,  K_RD,   1'b0, 5'h04, 16'h0000, 8'h00},  // R2 unmapped on page 0
      {4'd2,  K_RD,   1'b1, 5'h02, 16'h0000, 8'h01}   // R2 route read back
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic bus_page = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NPER-1:0] ev_tick = '0;
   logic ev_alarm = 1'b0, ev_tmr0 = 1'b0, ev_tmr1 = 1'b0, pf_event = 1'b0;
   logic pwr_ok = 1'b1;
   logic intr_n, mfo_n;
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   rtc_irq_ctrl #(.AW(AW), .DW(DW), .NPER(NPER)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_page(bus_page),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ev_tick(ev_tick), .ev_alarm(ev_alarm),
      .ev_tmr0(ev_tmr0), .ev_tmr1(ev_tmr1), .pf_event(pf_event),
      .pwr_ok(pwr_ok), .intr_n(intr_n), .mfo_n(mfo_n)
   );

   task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d actual=%02h expected=%02h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic set_events(input logic [15:0] d);
      ev_tick  = d[NPER-1:0];
      ev_alarm = d[5];
      ev_tmr0  = d[6];
      ev_tmr1  = d[7];
      pf_event = d[8];
   endtask

   // one vector per clock; called on a falling edge, returns on the next one
   task automatic run_vec(input logic [36:0] v, input logic [15:0] extra_ev);
      logic [3:0] req;
      logic [2:0] kind;
      logic [15:0] data;
      logic [7:0] exp;
      req = v[36:33];
      kind = v[32:30];
      data = v[23:8];
      exp = v[7:0];
      bus_page = v[29];
      bus_addr = AW'(v[28:24]);
      bus_rd = (kind == K_RD);
      bus_wr = (kind == K_WR);
      bus_wdata = data[DW-1:0];
      if (kind == K_EV) begin
         set_events(data);
         pwr_ok = !data[9];
      end else begin
         set_events(extra_ev);
      end
      #1;
      if (kind == K_RD) check(int'(req), bus_rdata, exp);
      if (kind == K_PIN) check(int'(req), {6'd0, mfo_n, intr_n}, exp);
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      bus_wr = 1'b0;
      set_events(16'h0000);
   endtask

   function automatic logic [36:0] mk(input logic [3:0] req, input logic [2:0] kind,
                                      input logic page, input logic [4:0] addr,
                                      input logic [15:0] data, input logic [7:0] exp);
      return {req, kind, page, addr, data, exp};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < N_VEC; i++) run_vec(VEC[i], 16'h0000);

      // R5 alarm event in the same cycle as its clearing write: event wins
      run_vec(mk(4'd5, K_WR, 1'b0, 5'h00, 16'h0004, 8'h00), 16'h0020);
      run_vec(mk(4'd5, K_RD, 1'b0, 5'h00, 16'h0000, 8'h04), 16'h0000);
      run_vec(mk(4'd5, K_WR, 1'b0, 5'h00, 16'h0004, 8'h00), 16'h0000);
      run_vec(mk(4'd10, K_RD, 1'b0, 5'h00, 16'h0000, 8'h01), 16'h0000);
      run_vec(mk(4'd0, K_IDLE, 1'b0, 5'h00, 16'h0000, 8'h00), 16'h0000);
      run_vec(mk(4'd5, K_RD, 1'b0, 5'h00, 16'h0000, 8'h00), 16'h0000);

      // R3 tick during the clearing read keeps its bit
      run_vec(mk(4'd3, K_EV, 1'b0, 5'h00, 16'h0001, 8'h00), 16'h0000);
      run_vec(mk(4'd3, K_RD, 1'b0, 5'h03, 16'h0000, 8'h01), 16'h0001);
      run_vec(mk(4'd3, K_RD, 1'b0, 5'h03, 16'h0000, 8'h01), 16'h0000);
      run_vec(mk(4'd3, K_RD, 1'b0, 5'h03, 16'h0000, 8'h00), 16'h0000);

      // R6 timer1 event during a status read stays set
      run_vec(mk(4'd6, K_EV, 1'b0, 5'h00, 16'h0080, 8'h00), 16'h0000);
      run_vec(mk(4'd6, K_RD, 1'b1, 5'h00, 16'h0000, 8'h10), 16'h0080);
      run_vec(mk(4'd6, K_RD, 1'b1, 5'h00, 16'h0000, 8'h10), 16'h0000);
      run_vec(mk(4'd6, K_RD, 1'b1, 5'h00, 16'h0000, 8'h00), 16'h0000);

      // R1 reset in mid-run
      run_vec(mk(4'd1, K_EV, 1'b0, 5'h00, 16'h0020, 8'h00), 16'h0000);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_vec(mk(4'd1, K_RD, 1'b0, 5'h00, 16'h0000, 8'h00), 16'h0000);
      run_vec(mk(4'd1, K_RD, 1'b1, 5'h04, 16'h0000, 8'h00), 16'h0000);
      run_vec(mk(4'd1, K_RD, 1'b1, 5'h02, 16'h0000, 8'h00), 16'h0000);
      run_vec(mk(4'd1, K_PIN, 1'b0, 5'h00, 16'h0000, 8'h03), 16'h0000);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule